// File: doc/BRIEF.md
# Chopper-Locked PGA Channel Scan Sequencer

This block scans a shared programmable-gain amplifier and its input multiplexer across a set of enabled channels. At each scan slot it reprograms the amplifier over SPI with two 16-bit register writes. The first write sets the input mode (differential, or single-ended against ground). The second sets the gain step and the selected channel. After a programmable settle time it pulses an ADC start-of-conversion strobe and tags it with the channel index.

Slots are derived from the amplifier's chopping clock. A slot boundary falls on every Nth rising chop edge, where N is an even divider. Conversions therefore stay phase-locked to the chopping ripple. If a slot boundary arrives while the previous switch or settle is still running, that slot is dropped and a sticky overrun flag is raised.

A host fills the per-channel table (enable, 4-bit gain code, mode bit) and the divider and settle registers. It then collects the strobes and tags alongside the ADC results.

Top module: `pga_scan_sequencer`

## Requirements
- R1: While reset is held (synchronous, active low) and on the cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, `adc_sot` is 0 and `overrun` is 0.
- R2: Every channel switch is two SPI frames of 16 bits each, sent MSB first, with `spi_sclk` idle low and MOSI stable while `spi_sclk` is high. The upper byte is the register address: the first frame of a switch uses address 0x06 and the second uses 0x00.
- R3: The low byte of the 0x06 frame is 0x01 when the channel's mode bit is 1 (single-ended) and 0x00 when it is 0 (differential).
- R4: The low byte of the 0x00 frame carries the gain code in bits 7:4 (0 means 1/16, doubling up to 11 meaning 128), a 0 in bit 3 and the channel index in bits 2:0. Gain codes 12 to 15 are sent as 11.
- R5: Each switch selects the next enabled channel above the last converted one, wrapping from the top index to the bottom. Disabled channels are skipped. After reset the first switch selects the lowest enabled channel.
- R6: `adc_sot` is a single-cycle pulse that occurs only while `spi_cs_n` is high. `adc_tag` carries the index of the channel set by the preceding switch.
- R7: `adc_sot` is seen exactly 2·SCK_HALF + `settle_cyc` + 1 clocks after the first cycle in which `spi_cs_n` is high at the end of the 0x00 frame.
- R8: A slot boundary occurs on every D-th rising chop edge. D is `div_ratio` with bit 0 cleared, and 0 or 1 give D = 2. With enough slack, successive strobes are D chop periods apart.
- R9: If a slot boundary arrives before the previous switch has strobed, no switch starts for that slot. `overrun` then goes to 1 and stays there until reset. With enough slack it stays 0.
- R10: Each frame has exactly 16 rising SCLK edges. `spi_cs_n` stays high for at least one SCLK period (2·SCK_HALF clocks) between frames.
- R11: With no channel enabled, chop edges cause no SPI frame, no strobe and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chop_clk | input | 1 | Amplifier chopping clock, asynchronous |
| cfg_en | input | NCH | Per-channel enable |
| cfg_gain | input | 4·NCH | Per-channel gain code, channel k in bits 4k+3:4k |
| cfg_se | input | NCH | Per-channel mode: 1 single-ended, 0 differential |
| div_ratio | input | DIV_W | Chop edges per slot (even, minimum 2) |
| settle_cyc | input | SET_W | Settle delay in clocks after the second write |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 1 | SPI chip select, active low |
| adc_sot | output | 1 | ADC start-of-conversion pulse |
| adc_tag | output | CH_W | Channel index of the conversion |
| overrun | output | 1 | Sticky flag: a slot was skipped |

## Verification
The bench decodes every SPI frame at the pins and predicts the address, mode byte, gain byte and channel from its own model of the scan order. It uses these table patterns:
- A single enabled channel with an out-of-range gain, which exposes gain clamping and single-channel wrap.
- Only the lowest and highest channels enabled, which separates a correct wrap from a linear scan.
- All channels enabled with alternating modes.
- Seeded random tables with random dividers and settle delays.

Odd divider values show that bit 0 of the divider is ignored. An empty table shows quiet operation. A divider of 1 forces overruns, and a later generous divider shows the flag is sticky. A mid-run reset shows the scan restarting at the lowest enabled channel.

// File: rtl/pga_seq_pkg.sv
// Package: shared constants, state types and SPI word builders for the
// PGA scan sequencer. Assumes at most 8 channels (3-bit channel field).
package pga_seq_pkg;

    localparam logic [7:0] ADDR_MODE = 8'h06;
    localparam logic [7:0] ADDR_GAIN = 8'h00;
    localparam logic [3:0] GAIN_TOP  = 4'd11;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_MODE,
        SQ_GAIN,
        SQ_SETTLE
    } seq_state_t;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_LEAD,
        SP_HI,
        SP_LO,
        SP_HOLD,
        SP_GAP
    } spi_state_t;

    // Input-mode register write: bit 0 selects single-ended.
    function automatic logic [15:0] mode_word(input logic single_ended);
        return {ADDR_MODE, 7'd0, single_ended};
    endfunction

    // Gain/channel register write: gain saturates at the top step.
    function automatic logic [15:0] gain_word(input logic [3:0] gain,
                                              input logic [2:0] chan);
        logic [3:0] g;
        g = (gain > GAIN_TOP) ? GAIN_TOP : gain;
        return {ADDR_GAIN, g, 1'b0, chan};
    endfunction

endpackage

// File: rtl/pga_spi_word.sv
// Module: pga_spi_word
// Sends one 16-bit word MSB first in SPI mode 0. CS_n drops half an SCLK
// period before the first rising edge and rises half a period after the
// last falling edge. It then stays high for one full SCLK period before
// 'done' pulses.
// Assumes: 'start' is only pulsed while idle; HALF >= 1 system clocks.
module pga_spi_word
    import pga_seq_pkg::*;
#(
    parameter int HALF = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] word,
    output logic        done,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n
);
    localparam int CNT_W = $clog2(2 * HALF + 1);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(2 * HALF - 1);

    spi_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       bit_n;
    logic [15:0]      shreg;

    // Frame state machine: phases timed in half SCLK periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SP_IDLE;
            cnt   <= '0;
            bit_n <= '0;
            shreg <= '0;
        end else begin
            case (state)
                SP_IDLE: if (start) begin
                    shreg <= word;
                    bit_n <= '0;
                    cnt   <= '0;
                    state <= SP_LEAD;
                end
                SP_LEAD: if (cnt == HALF_END) begin
                    cnt   <= '0;
                    state <= SP_HI;
                end else cnt <= cnt + 1'b1;
                SP_HI: if (cnt == HALF_END) begin
                    cnt <= '0;
                    if (bit_n == 4'd15) state <= SP_HOLD;
                    else begin
                        shreg <= {shreg[14:0], 1'b0};
                        bit_n <= bit_n + 1'b1;
                        state <= SP_LO;
                    end
                end else cnt <= cnt + 1'b1;
                SP_LO: if (cnt == HALF_END) begin
                    cnt   <= '0;
                    state <= SP_HI;
                end else cnt <= cnt + 1'b1;
                SP_HOLD: if (cnt == HALF_END) begin
                    cnt   <= '0;
                    state <= SP_GAP;
                end else cnt <= cnt + 1'b1;
                SP_GAP: if (cnt == GAP_END) begin
                    cnt   <= '0;
                    state <= SP_IDLE;
                end else cnt <= cnt + 1'b1;
                default: state <= SP_IDLE;
            endcase
        end
    end

    // Pin decode from the registered phase.
    always_comb begin
        sclk = (state == SP_HI);
        cs_n = (state == SP_IDLE) || (state == SP_GAP);
        mosi = shreg[15];
        done = (state == SP_GAP) && (cnt == GAP_END);
    end

endmodule

// File: rtl/pga_slot_timer.sv
// Module: pga_slot_timer
// Synchronises the asynchronous chop clock, detects its rising edges and
// emits a one-cycle slot tick on every D-th edge. D is div_ratio with
// bit 0 cleared; 0 and 1 act as 2.
// Assumes: chop period spans several system clocks.
module pga_slot_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chop_in,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             slot_tick
);
    logic             meta, sync, prev;
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] edge_cnt;
    logic             chop_rise;

    // Two-flop synchroniser plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {meta, sync, prev} <= 3'b000;
        else        {meta, sync, prev} <= {chop_in, meta, sync};
    end

    // Effective even divider with a floor of two.
    always_comb begin
        lim       = {div_ratio[DIV_W-1:1], 1'b0};
        if (lim == '0) lim = DIV_W'(2);
        chop_rise = sync & ~prev;
    end

    // Edge counter: tick on the last edge of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt  <= '0;
            slot_tick <= 1'b0;
        end else begin
            slot_tick <= 1'b0;
            if (chop_rise) begin
                if (edge_cnt >= lim - 1'b1) begin
                    edge_cnt  <= '0;
                    slot_tick <= 1'b1;
                end else edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pga_chan_pick.sv
// Module: pga_chan_pick
// Combinational search for the nearest enabled channel above 'last_ch',
// wrapping around. 'found' is low when no channel is enabled.
// Assumes: last_ch < NCH.
module pga_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  en,
    input  logic [CH_W-1:0] last_ch,
    output logic [CH_W-1:0] next_ch,
    output logic            found
);
    // Farthest candidate first so the nearest enabled one wins.
    always_comb begin
        next_ch = last_ch;
        found   = 1'b0;
        for (int k = NCH; k >= 1; k--) begin
            int idx;
            idx = (int'(last_ch) + k) % NCH;
            if (en[idx]) begin
                next_ch = CH_W'(idx);
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pga_scan_sequencer.sv
// Module: pga_scan_sequencer (top)
// On each chop-derived slot tick, picks the next enabled channel and writes
// the input-mode register, then the gain/channel register. It waits
// settle_cyc clocks and pulses adc_sot with the channel tag. A tick that
// arrives mid-switch is dropped and sets the sticky overrun flag.
// Assumes: NCH <= 8; configuration held stable while scanning.
module pga_scan_sequencer
    import pga_seq_pkg::*;
#(
    parameter int  NCH      = 8,
    parameter int  SCK_HALF = 25,
    parameter int  DIV_W    = 8,
    parameter int  SET_W    = 12,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chop_clk,
    input  logic [NCH-1:0]   cfg_en,
    input  logic [NCH*4-1:0] cfg_gain,
    input  logic [NCH-1:0]   cfg_se,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [SET_W-1:0] settle_cyc,
    output logic             spi_sclk,
    output logic             spi_mosi,
    output logic             spi_cs_n,
    output logic             adc_sot,
    output logic [CH_W-1:0]  adc_tag,
    output logic             overrun
);
    seq_state_t      state;
    logic            slot_tick;
    logic [CH_W-1:0] pick_ch, cur_ch, last_ch;
    logic            pick_ok;
    logic            spi_start, spi_done;
    logic [15:0]     spi_word;
    logic [SET_W-1:0] set_cnt;

    pga_slot_timer #(.DIV_W(DIV_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .chop_in   (chop_clk),
        .div_ratio (div_ratio),
        .slot_tick (slot_tick)
    );

    pga_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .en      (cfg_en),
        .last_ch (last_ch),
        .next_ch (pick_ch),
        .found   (pick_ok)
    );

    pga_spi_word #(.HALF(SCK_HALF)) u_spi (
        .clk   (clk),
        .rst_n (rst_n),
        .start (spi_start),
        .word  (spi_word),
        .done  (spi_done),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

    // Slot sequencing: mode write, gain write, settle, strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cur_ch    <= '0;
            last_ch   <= CH_W'(NCH - 1);
            spi_start <= 1'b0;
            spi_word  <= '0;
            set_cnt   <= '0;
            adc_sot   <= 1'b0;
            adc_tag   <= '0;
            overrun   <= 1'b0;
        end else begin
            spi_start <= 1'b0;
            adc_sot   <= 1'b0;
            if (slot_tick && state != SQ_IDLE) overrun <= 1'b1;
            case (state)
                SQ_IDLE: if (slot_tick && pick_ok) begin
                    cur_ch    <= pick_ch;
                    spi_word  <= mode_word(cfg_se[pick_ch]);
                    spi_start <= 1'b1;
                    state     <= SQ_MODE;
                end
                SQ_MODE: if (spi_done) begin
                    spi_word  <= gain_word(cfg_gain[int'(cur_ch)*4 +: 4], 3'(cur_ch));
                    spi_start <= 1'b1;
                    state     <= SQ_GAIN;
                end
                SQ_GAIN: if (spi_done) begin
                    set_cnt <= '0;
                    state   <= SQ_SETTLE;
                end
                SQ_SETTLE: if (set_cnt == settle_cyc) begin
                    adc_sot <= 1'b1;
                    adc_tag <= cur_ch;
                    last_ch <= cur_ch;
                    state   <= SQ_IDLE;
                end else set_cnt <= set_cnt + 1'b1;
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pga_scan_sequencer_chk.sv
// Checker: temporal properties of the sequencer pins, bound into the top.
module pga_scan_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic adc_sot,
    input logic overrun
);
    // R6: strobe lasts one cycle
    a_r6_sot_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sot |=> !adc_sot);

    // R6: strobe only outside an SPI frame
    a_r6_sot_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sot |-> spi_cs_n);

    // R10: clock idles low whenever select is released
    a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2: data does not move while SCLK is high inside a frame
    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi));

    // R9: overrun never clears without reset
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind pga_scan_sequencer pga_scan_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .adc_sot  (adc_sot),
    .overrun  (overrun)
);

// File: tb/test_pga_scan_sequencer.sv
`timescale 1ns/1ps
module test_pga_scan_sequencer;
    localparam int NCH   = 8;
    localparam int H     = 2;
    localparam int DIV_W = 8;
    localparam int SET_W = 12;
    localparam int CP    = 48;

    logic clk = 1'b0, rst_n = 1'b0, chop = 1'b0;
    logic [NCH-1:0]   cfg_en = '0, cfg_se = '0;
    logic [NCH*4-1:0] cfg_gain = '0;
    logic [DIV_W-1:0] div_ratio = 8'd4;
    logic [SET_W-1:0] settle = '0;
    logic spi_sclk, spi_mosi, spi_cs_n, adc_sot, overrun;
    logic [2:0] adc_tag;

    int checks = 0, errors = 0, cyc = 0;
    bit chop_on = 1'b0;
    int chop_cnt = 0;

    pga_scan_sequencer #(.NCH(NCH), .SCK_HALF(H), .DIV_W(DIV_W), .SET_W(SET_W))
    i_pga_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .chop_clk(chop), .cfg_en(cfg_en),
        .cfg_gain(cfg_gain), .cfg_se(cfg_se), .div_ratio(div_ratio),
        .settle_cyc(settle), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .adc_sot(adc_sot), .adc_tag(adc_tag),
        .overrun(overrun)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Chop source: period CP clocks, changes on falling clock edges.
    always @(negedge clk) begin
        if (chop_on) begin
            if (chop_cnt == CP/2 - 1) begin chop <= ~chop; chop_cnt <= 0; end
            else chop_cnt <= chop_cnt + 1;
        end else chop_cnt <= 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt(input logic [NCH-1:0] en, input int last);
        for (int k = 1; k <= NCH; k++) if (en[(last + k) % NCH]) return (last + k) % NCH;
        return -1;
    endfunction
    function automatic int geff(input int g); return (g > 11) ? 11 : g; endfunction
    function automatic int deff(input int d);
        int e; e = d & ~1; return (e == 0) ? 2 : e;
    endfunction

    // Pin-level monitor and model
    bit p_sclk = 0, p_cs = 1, p_sot = 0, seen_frame = 0, have_prev = 0, rate_chk = 0;
    logic [15:0] sh = '0;
    int nb = 0, want_gain = 0, exp_ch = 0, exp_last = NCH - 1;
    int cs_up_cyc = 0, gain_up_cyc = 0, prev_sot_cyc = 0, nsot = 0, nframes = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            want_gain = 0; exp_last = NCH - 1; seen_frame = 0; have_prev = 0;
            p_sclk = 0; p_cs = 1; p_sot = 0;
        end else begin
            if (p_cs && !spi_cs_n) begin
                if (seen_frame) chk(cyc - cs_up_cyc >= 2*H, "R10 cs gap", cyc - cs_up_cyc, 2*H);
                nb = 0;
            end
            if (!spi_cs_n && !p_sclk && spi_sclk) begin sh = {sh[14:0], spi_mosi}; nb++; end
            if (!p_cs && spi_cs_n) begin
                seen_frame = 1; cs_up_cyc = cyc; nframes++;
                chk(nb == 16, "R10 bits per frame", nb, 16);
                if (want_gain == 0) begin
                    exp_ch = nxt(cfg_en, exp_last);
                    chk(sh[15:8] == 8'h06, "R2 first address", int'(sh[15:8]), 6);
                    chk(int'(sh[7:0]) == int'(cfg_se[exp_ch]), "R3 mode byte", int'(sh[7:0]), int'(cfg_se[exp_ch]));
                    want_gain = 1;
                end else begin
                    chk(sh[15:8] == 8'h00, "R2 second address", int'(sh[15:8]), 0);
                    chk(int'(sh[7:4]) == geff(int'(cfg_gain[exp_ch*4 +: 4])), "R4 gain field",
                        int'(sh[7:4]), geff(int'(cfg_gain[exp_ch*4 +: 4])));
                    chk(int'(sh[3:0]) == exp_ch, "R5 channel field", int'(sh[3:0]), exp_ch);
                    gain_up_cyc = cyc; want_gain = 0;
                end
            end
            if (adc_sot && p_sot) chk(0, "R6 strobe width", 2, 1);
            if (adc_sot && !p_sot) begin
                chk(int'(adc_tag) == exp_ch, "R6 tag", int'(adc_tag), exp_ch);
                chk(cyc - gain_up_cyc == 2*H + int'(settle) + 1, "R7 settle timing",
                    cyc - gain_up_cyc, 2*H + int'(settle) + 1);
                if (have_prev && rate_chk)
                    chk(cyc - prev_sot_cyc == deff(int'(div_ratio)) * CP, "R8 slot spacing",
                        cyc - prev_sot_cyc, deff(int'(div_ratio)) * CP);
                prev_sot_cyc = cyc; have_prev = 1; exp_last = exp_ch; nsot++;
            end
            p_sclk = spi_sclk; p_cs = spi_cs_n; p_sot = adc_sot;
        end
    end

    task automatic run_phase(input int n, input bit rate);
        int tgt;
        have_prev = 0; rate_chk = rate; tgt = nsot + n;
        chop_on = 1;
        wait (nsot >= tgt);
        chop_on = 0;
        repeat (400) @(posedge clk);
    endtask

    task automatic check_reset_pins();
        chk(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1 sclk", int'(spi_sclk), 0);
        chk(adc_sot == 1'b0, "R1 sot", int'(adc_sot), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        int fr0, so0;
        seed_v = $urandom(32'd2024);
        repeat (4) @(posedge clk);
        @(negedge clk) check_reset_pins();
        rst_n = 1'b1;
        @(negedge clk) check_reset_pins();

        // R4 clamp, R5 single-channel wrap
        cfg_en = 8'h04; cfg_se = 8'h04; cfg_gain = {8{4'hD}}; div_ratio = 8'd4; settle = 12'd0;
        run_phase(5, 1);
        // R5 wrap top to bottom, R8 odd divider ignores bit 0
        cfg_en = 8'h81; cfg_se = 8'h80; cfg_gain = 32'hF000_0000; div_ratio = 8'd5; settle = 12'd7;
        run_phase(6, 1);
        // all channels, alternating modes
        cfg_en = 8'hFF; cfg_se = 8'h55; cfg_gain = 32'h9876_5432; div_ratio = 8'd8; settle = 12'd30;
        run_phase(10, 1);
        // seeded random tables
        for (int i = 0; i < 6; i++) begin
            cfg_en = NCH'($urandom_range(1, 255));
            cfg_se = NCH'($urandom);
            cfg_gain = $urandom;
            div_ratio = DIV_W'($urandom_range(4, 9));
            settle = SET_W'($urandom_range(0, 30));
            run_phase(6, 1);
        end

        // R11 empty table
        fr0 = nframes; so0 = nsot;
        cfg_en = '0; chop_on = 1;
        repeat (1000) @(posedge clk);
        chop_on = 0;
        @(negedge clk);
        chk(nframes == fr0, "R11 frames", nframes, fr0);
        chk(nsot == so0, "R11 strobes", nsot, so0);
        chk(overrun == 1'b0, "R9 no overrun with slack", int'(overrun), 0);

        // R9 overrun with divider 1 (acts as 2)
        cfg_en = 8'h0F; cfg_se = 8'h03; cfg_gain = 32'h0000_1B5A; div_ratio = 8'd1; settle = 12'd10;
        run_phase(4, 0);
        @(negedge clk) chk(overrun == 1'b1, "R9 overrun raised", int'(overrun), 1);
        cfg_en = 8'h30; div_ratio = 8'd8; settle = 12'd5;
        run_phase(3, 1);
        @(negedge clk) chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);

        // R1 reset mid-run, R5 restart at lowest enabled
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) check_reset_pins();
        rst_n = 1'b1;
        cfg_en = 8'h12; cfg_se = 8'h10; cfg_gain = 32'h0007_0030; div_ratio = 8'd6; settle = 12'd3;
        run_phase(4, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule